// File: doc/BRIEF.md
# Smart-Card Receive Byte Queue with Level and Overrun Status

This block holds the bytes that a smart-card deserializer delivers until the host reads them. It is a 16-entry first-in first-out byte store. The oldest unread byte is always visible on the read data port, and a read strobe removes it. Around the store sit three status flags and one interrupt line:

- A level flag compares the number of unread bytes with a 4-bit programmable threshold.
- A new-data flag records that a byte was stored.
- A sticky overrun flag records that a byte arrived with nowhere to go.

The block handles an arriving byte that finds the store full in one of two ways, chosen by a mode input. In retransmit mode it refuses the byte and raises a one-cycle request for a NACK pulse, so that the card repeats the byte. In drop mode it discards the byte, and it goes on discarding every received byte until software clears the overrun flag. Shaping the NACK pulse on the serial line is left to the transmitter logic.

Top module: `scrx_fifo_top`

## Requirements
- R1: Bytes leave in arrival order. `rd_data` shows the oldest unread byte while the queue is non-empty. A pulse on `rd_en` removes that byte on the clock edge. A read while the queue is empty is ignored and moves no pointer. The queue holds 16 bytes.
- R2: `thr_flag` is 1 exactly when the unread count is greater than or equal to `thr_level`. It follows reads, writes and threshold changes with no clear action. A threshold of 0 keeps it at 1.
- R3: `ovf_flag` goes to 1 on the edge after a byte arrives while the queue is full and no read is taken in the same cycle. It then stays at 1 until a cycle with `w1c_wr`=1 and `w1c_val[0]`=1. When a new overrun and the clear fall in the same cycle, the flag stays set.
- R4: With `nack_on_full`=1, a byte refused because the queue is full is not stored, and `nack_req` is 1 for the one cycle after that byte. While `ovf_flag` stays set, later bytes are still stored whenever there is room.
- R5: With `nack_on_full`=0, the byte that finds the queue full is lost and `nack_req` stays 0. Every byte received while `ovf_flag` is 1 is also lost, even when there is room, until the flag is cleared.
- R6: A write and a read in the same cycle while the queue is full are both taken. The count stays at 16 and no overrun is recorded.
- R7: `new_flag` goes to 1 on the edge after a byte is stored. It is cleared by `w1c_wr`=1 with `w1c_val[1]`=1. When a byte is stored in the same cycle as the clear, the flag stays set.
- R8: `irq` is the OR of `thr_flag`, `new_flag` and `ovf_flag`, each gated by its own mask input. A mask bit of 1 blocks its flag.
- R9: After reset the queue is empty, and `new_flag`, `ovf_flag` and `nack_req` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Received byte strobe from the deserializer |
| wr_data | input | 8 | Received byte |
| rd_en | input | 1 | Host read strobe, pops the oldest byte |
| rd_data | output | 8 | Oldest unread byte |
| thr_level | input | 4 | Unread-count threshold |
| nack_on_full | input | 1 | 1 = refuse the byte and request a NACK, 0 = drop |
| thr_mask | input | 1 | 1 blocks `thr_flag` from `irq` |
| data_mask | input | 1 | 1 blocks `new_flag` from `irq` |
| ovf_mask | input | 1 | 1 blocks `ovf_flag` from `irq` |
| w1c_wr | input | 1 | Write strobe for the flag clear port |
| w1c_val | input | 2 | Bit 0 clears the overrun flag, bit 1 clears the new-data flag |
| thr_flag | output | 1 | Unread count is at or above the threshold |
| new_flag | output | 1 | A byte has been stored since the last clear |
| ovf_flag | output | 1 | Sticky overrun indicator |
| nack_req | output | 1 | One-cycle request for a retransmission NACK |
| irq | output | 1 | Interrupt, the OR of the unmasked flags |

## Verification
The bench pushes the queue to its 16-byte limit and then tries a 17th byte in both overrun modes:

- A design that stored the refused byte, or let a byte through in drop mode while the flag was set, would show up as a byte out of place in the read-back order.
- A design that fired `nack_req` in drop mode, or for more than one cycle, would be caught at the cycle after the byte.

The remaining corner cases are each set against one wrong behaviour:

- A read and a write together at full: a design that counted this as an overrun would raise `ovf_flag`.
- A clear in the same cycle as a new event: a design that let the clear win would drop the flag.
- A read on an empty queue: a design that moved a pointer would return a stale byte later.
- Threshold raises and threshold 0: a design that latched the level flag would keep a stale value.

// File: rtl/scrx_pkg.sv
// Package: shared constants for the smart-card receive queue.
// Assumes the flag clear port is two bits wide with the bit positions below.
package scrx_pkg;
    localparam int W1C_W       = 2;
    localparam int W1C_OVF_BIT = 0;
    localparam int W1C_NEW_BIT = 1;
endpackage

// File: rtl/scrx_store.sv
// scrx_store: circular byte storage with head/tail pointers and an occupancy count.
// Assumes push is only asserted when there is room (or a pop happens in the
// same cycle) and pop only when count is non-zero; scrx_admit guarantees both.
// The head entry is presented combinationally (first-word fall-through).
module scrx_store #(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 16,
    localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW    = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic              pop,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic [CW-1:0]     count
);
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    logic [DATA_W-1:0] mem [DEPTH];
    logic [AW-1:0]     wr_ptr;
    logic [AW-1:0]     rd_ptr;

    // Store the incoming byte at the tail position.
    always_ff @(posedge clk) begin
        if (push) mem[wr_ptr] <= wdata;
    end

    // Advance the tail and head pointers, wrapping at DEPTH-1.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
        end else begin
            if (push) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
            if (pop)  rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
        end
    end

    // Track occupancy from the push/pop pair.
    always_ff @(posedge clk) begin
        if (!rst_n) count <= '0;
        else if (push && !pop) count <= count + 1'b1;
        else if (pop && !push) count <= count - 1'b1;
    end

    // Present the oldest byte.
    always_comb rdata = mem[rd_ptr];

    // R1: occupancy never exceeds the queue depth.
    p_count_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CW'(DEPTH));
    // R1: the admission logic never pops an empty queue.
    p_no_empty_pop_r1: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> count != '0);
endmodule

// File: rtl/scrx_admit.sv
// scrx_admit: decides, per cycle, whether a host read and a received byte are taken.
// Assumes count is the registered occupancy of scrx_store. In drop mode a set
// overrun flag blocks every received byte; in NACK mode only lack of room does.
module scrx_admit #(
    parameter int DEPTH = 16,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          wr_en,
    input  logic          rd_en,
    input  logic [CW-1:0] count,
    input  logic          ovf_flag,
    input  logic          nack_on_full,
    output logic          do_wr,
    output logic          do_rd,
    output logic          full_hit
);
    logic room;
    logic drop_lock;

    // Work out room, the drop-mode lock and the resulting accept decisions.
    always_comb begin
        do_rd     = rd_en && (count != '0);
        room      = (count < CW'(DEPTH)) || do_rd;
        drop_lock = ovf_flag && !nack_on_full;
        full_hit  = wr_en && !room;
        do_wr     = wr_en && room && !drop_lock;
    end
endmodule

// File: rtl/scrx_status.sv
// scrx_status: level, new-data and overrun flags, NACK request and interrupt.
// Assumes do_wr and full_hit come from scrx_admit for the same cycle; flag sets
// take priority over write-one-to-clear requests arriving in the same cycle.
module scrx_status
    import scrx_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int THR_W = 4,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CW-1:0]    count,
    input  logic [THR_W-1:0] thr_level,
    input  logic             do_wr,
    input  logic             full_hit,
    input  logic             nack_on_full,
    input  logic             w1c_wr,
    input  logic [W1C_W-1:0] w1c_val,
    input  logic             thr_mask,
    input  logic             data_mask,
    input  logic             ovf_mask,
    output logic             thr_flag,
    output logic             new_flag,
    output logic             ovf_flag,
    output logic             nack_req,
    output logic             irq
);
    localparam int XW = (CW > THR_W) ? CW : THR_W;

    logic clr_ovf;
    logic clr_new;

    // Decode the clear port.
    always_comb begin
        clr_ovf = w1c_wr && w1c_val[W1C_OVF_BIT];
        clr_new = w1c_wr && w1c_val[W1C_NEW_BIT];
    end

    // New-data flag: set on a stored byte, set wins over clear.
    always_ff @(posedge clk) begin
        if (!rst_n)       new_flag <= 1'b0;
        else if (do_wr)   new_flag <= 1'b1;
        else if (clr_new) new_flag <= 1'b0;
    end

    // Overrun flag: sticky, set wins over clear.
    always_ff @(posedge clk) begin
        if (!rst_n)        ovf_flag <= 1'b0;
        else if (full_hit) ovf_flag <= 1'b1;
        else if (clr_ovf)  ovf_flag <= 1'b0;
    end

    // One-cycle NACK request for a byte refused in retransmit mode.
    always_ff @(posedge clk) begin
        if (!rst_n) nack_req <= 1'b0;
        else        nack_req <= full_hit && nack_on_full;
    end

    // Level flag: unread count against the programmable threshold.
    always_comb thr_flag = XW'(count) >= XW'(thr_level);

    // Interrupt: OR of the unmasked flags.
    always_comb irq = (thr_flag && !thr_mask) || (new_flag && !data_mask) ||
                      (ovf_flag && !ovf_mask);

    // R3: without a clear request the overrun flag holds.
    p_ovf_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_flag && !clr_ovf) |=> ovf_flag);
    // R4: a refused byte in retransmit mode requests a NACK next cycle.
    p_nack_follows_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (full_hit && nack_on_full) |=> nack_req);
    // R5: drop mode never requests a NACK.
    p_no_nack_drop_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !nack_on_full |=> !nack_req || $past(nack_on_full));
    // R7: a stored byte always leaves the new-data flag set.
    p_new_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
        do_wr |=> new_flag);
endmodule

// File: rtl/scrx_fifo_top.sv
// scrx_fifo_top: smart-card receive byte queue with level, new-data and
// overrun status and a masked interrupt. Assumes one received byte per
// wr_en pulse and that the host only reads rd_data while the queue is non-empty.
module scrx_fifo_top
    import scrx_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 16,
    parameter int THR_W  = 4,
    localparam int CW    = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rd_data,
    input  logic [THR_W-1:0]  thr_level,
    input  logic              nack_on_full,
    input  logic              thr_mask,
    input  logic              data_mask,
    input  logic              ovf_mask,
    input  logic              w1c_wr,
    input  logic [W1C_W-1:0]  w1c_val,
    output logic              thr_flag,
    output logic              new_flag,
    output logic              ovf_flag,
    output logic              nack_req,
    output logic              irq
);
    logic [CW-1:0] count;
    logic          do_wr;
    logic          do_rd;
    logic          full_hit;

    scrx_admit #(.DEPTH(DEPTH)) u_admit (
        .wr_en(wr_en), .rd_en(rd_en), .count(count), .ovf_flag(ovf_flag),
        .nack_on_full(nack_on_full), .do_wr(do_wr), .do_rd(do_rd),
        .full_hit(full_hit)
    );

    scrx_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
        .clk(clk), .rst_n(rst_n), .push(do_wr), .pop(do_rd),
        .wdata(wr_data), .rdata(rd_data), .count(count)
    );

    scrx_status #(.DEPTH(DEPTH), .THR_W(THR_W)) u_status (
        .clk(clk), .rst_n(rst_n), .count(count), .thr_level(thr_level),
        .do_wr(do_wr), .full_hit(full_hit), .nack_on_full(nack_on_full),
        .w1c_wr(w1c_wr), .w1c_val(w1c_val), .thr_mask(thr_mask),
        .data_mask(data_mask), .ovf_mask(ovf_mask), .thr_flag(thr_flag),
        .new_flag(new_flag), .ovf_flag(ovf_flag), .nack_req(nack_req),
        .irq(irq)
    );

    // R2: a zero threshold always reports the level flag.
    p_thr_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (thr_level == '0) |-> thr_flag);
    // R6: read plus write at full keeps the queue full without an overrun.
    p_full_rdwr_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && rd_en && count == CW'(DEPTH) && !ovf_flag) |=>
        (!ovf_flag && count == CW'(DEPTH)));
    // R5: in drop mode with the overrun flag set, no byte is added.
    p_drop_lock_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_flag && !nack_on_full && wr_en) |=> count <= $past(count));
    // R8: with every mask set the interrupt stays low.
    p_irq_masked_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (thr_mask && data_mask && ovf_mask) |-> !irq);
endmodule

// File: tb/test_scrx_fifo_top.sv
module test_scrx_fifo_top;
    localparam int DEPTH = 16;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0, rd_en = 1'b0, w1c_wr = 1'b0;
    logic [7:0] wr_data = '0;
    logic [1:0] w1c_val = '0;
    logic [3:0] thr_level = 4'd4;
    logic       nack_on_full = 1'b1;
    logic       thr_mask = 1'b0, data_mask = 1'b0, ovf_mask = 1'b0;
    logic [7:0] rd_data;
    logic       thr_flag, new_flag, ovf_flag, nack_req, irq;

    int total = 0;
    int bad = 0;
    bit done = 0;
    logic [7:0] mq[$];
    bit movf = 0;
    bit mnew = 0;
    bit mnack = 0;

    always #4 clk = ~clk;

    scrx_fifo_top i_scrx_fifo_top (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .rd_en(rd_en), .rd_data(rd_data), .thr_level(thr_level),
        .nack_on_full(nack_on_full), .thr_mask(thr_mask),
        .data_mask(data_mask), .ovf_mask(ovf_mask), .w1c_wr(w1c_wr),
        .w1c_val(w1c_val), .thr_flag(thr_flag), .new_flag(new_flag),
        .ovf_flag(ovf_flag), .nack_req(nack_req), .irq(irq)
    );

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Compare every output flag with the bench's own expectations.
    task automatic chk_flags();
        bit ethr;
        bit eirq;
        ethr = (mq.size() >= int'(thr_level));
        eirq = (ethr && !thr_mask) || (mnew && !data_mask) || (movf && !ovf_mask);
        chk("R2 thr_flag", thr_flag, ethr);
        chk("R7 new_flag", new_flag, mnew);
        chk("R3 ovf_flag", ovf_flag, movf);
        chk("R4 nack_req", nack_req, mnack);
        chk("R8 irq", irq, eirq);
    endtask

    // Driver and monitor for one cycle: pushes expected bytes into the
    // scoreboard, pops and compares on reads, then checks the flags.
    task automatic cyc(input bit wr, input logic [7:0] wd, input bit rd,
                       input bit w1c, input logic [1:0] wv);
        bit drd, space, store, oset;
        @(negedge clk);
        wr_en = wr; wr_data = wd; rd_en = rd; w1c_wr = w1c; w1c_val = wv;
        drd = rd && (mq.size() > 0);
        if (drd) begin
            chk("R1 head byte", rd_data, mq[0]);
            void'(mq.pop_front());
        end
        space = (mq.size() < DEPTH);
        store = wr && space && !(movf && !nack_on_full);
        oset  = wr && !space;
        mnack = oset && nack_on_full;
        if (store) mq.push_back(wd);
        if (oset) movf = 1;
        else if (w1c && wv[0]) movf = 0;
        if (store) mnew = 1;
        else if (w1c && wv[1]) mnew = 0;
        @(posedge clk);
        #1;
        chk_flags();
        wr_en = 0; rd_en = 0; w1c_wr = 0; w1c_val = '0;
    endtask

    task automatic idle_thr(input logic [3:0] t);
        thr_level = t;
        cyc(0, 8'h00, 0, 0, 2'b00);
    endtask

    initial begin
        #(8 * 100000);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        // R9: reset state
        chk("R9 new_flag reset", new_flag, 0);
        chk("R9 ovf_flag reset", ovf_flag, 0);
        chk("R9 nack_req reset", nack_req, 0);
        chk("R9 thr_flag empty", thr_flag, 0);
        @(negedge clk);
        rst_n = 1'b1;
        idle_thr(4'd0);                       // R2: threshold 0 means always set
        chk("R2 thr zero", thr_flag, 1);
        idle_thr(4'd4);
        for (int i = 0; i < 4; i++) cyc(1, 8'h10 + 8'(i), 0, 0, 2'b00);
        idle_thr(4'd5);                       // R2: raising threshold clears
        chk("R2 raised thr", thr_flag, 0);
        idle_thr(4'd4);
        cyc(0, 8'h00, 0, 1, 2'b10);           // R7: clear new-data flag
        cyc(1, 8'h14, 0, 1, 2'b10);           // R7: set wins over clear
        chk("R7 set beats clear", new_flag, 1);
        cyc(0, 8'h00, 1, 0, 2'b00);           // R2: read lowers the count
        // fill to full in retransmit mode
        nack_on_full = 1'b1;
        while (mq.size() < DEPTH) cyc(1, 8'h20 + 8'(mq.size()), 0, 0, 2'b00);
        idle_thr(4'd15);
        cyc(1, 8'hEE, 0, 0, 2'b00);           // R4: refused, NACK next cycle
        chk("R4 nack pulse", nack_req, 1);
        cyc(1, 8'hED, 0, 1, 2'b01);           // R3: overrun beats clear
        chk("R3 set beats clear", ovf_flag, 1);
        cyc(0, 8'h00, 0, 0, 2'b00);
        chk("R4 nack one cycle", nack_req, 0);
        cyc(0, 8'h00, 1, 0, 2'b00);           // R4: room again, flag still set
        cyc(1, 8'h77, 0, 0, 2'b00);           // R4: stored while ovf set
        cyc(0, 8'h00, 0, 1, 2'b01);           // R3: clear overrun
        cyc(1, 8'h99, 1, 0, 2'b00);           // R6: read+write at full
        chk("R6 no ovf on rd+wr full", ovf_flag, 0);
        while (mq.size() > 0) cyc(0, 8'h00, 1, 0, 2'b00);   // R1 order
        cyc(0, 8'h00, 1, 0, 2'b00);           // R1: read on empty ignored
        cyc(1, 8'h5A, 0, 0, 2'b00);
        cyc(0, 8'h00, 1, 0, 2'b00);           // R1: byte after empty read
        // drop mode
        nack_on_full = 1'b0;
        while (mq.size() < DEPTH) cyc(1, 8'h40 + 8'(mq.size()), 0, 0, 2'b00);
        cyc(1, 8'hE1, 0, 0, 2'b00);           // R5: lost, no NACK
        chk("R5 no nack in drop", nack_req, 0);
        cyc(0, 8'h00, 1, 0, 2'b00);
        cyc(0, 8'h00, 1, 0, 2'b00);
        cyc(1, 8'hAB, 0, 0, 2'b00);           // R5: lost despite room
        chk("R5 dropped with room", thr_flag, 0);
        cyc(0, 8'h00, 0, 1, 2'b01);
        cyc(1, 8'hCD, 0, 0, 2'b00);           // R5: accepted after clear
        cyc(1, 8'hCE, 0, 0, 2'b00);
        cyc(1, 8'hCF, 0, 0, 2'b00);           // full again -> overrun
        // R8: masking
        thr_mask = 1'b1; data_mask = 1'b1; ovf_mask = 1'b1;
        cyc(0, 8'h00, 0, 0, 2'b00);
        chk("R8 all masked", irq, 0);
        ovf_mask = 1'b0;
        cyc(0, 8'h00, 0, 0, 2'b00);
        chk("R8 ovf unmasked", irq, 1);
        ovf_mask = 1'b1; data_mask = 1'b0;
        cyc(0, 8'h00, 0, 0, 2'b00);
        thr_mask = 1'b0; data_mask = 1'b1;
        cyc(0, 8'h00, 0, 1, 2'b11);
        while (mq.size() > 0) cyc(0, 8'h00, 1, 0, 2'b00);   // R1 order
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule